// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block divides one 32-bit integer by another and returns the quotient and the remainder together. Each operation runs over several clock cycles. The number of cycles depends on how large the dividend is, so a small dividend finishes sooner than a full-width one. An `is_signed` input selects two's-complement or unsigned operands for each operation.

An execute stage starts an operation by raising `start` together with the two operands. The divider accepts the request on a clock edge at which it is not busy. It then raises `busy`, and the surrounding stage holds while `busy` is high. When the results are ready, the divider pulses `done` for one cycle. The quotient and remainder stay registered until the next operation completes.

Inside the block there are three parts. A leading-zero counter measures the absolute dividend. A restoring shift-subtract step is applied once for each significant dividend bit. A final stage fixes up the signs and handles the special cases.

Top module: `idiv_top`

## Requirements
- R1: In unsigned mode (`is_signed`=0) with a nonzero divisor, `quotient` = floor(dividend/divisor) and `remainder` = dividend − quotient·divisor.
- R2: In signed mode (`is_signed`=1) with a nonzero divisor, the quotient is truncated toward zero and the remainder has the sign of the dividend (or is zero). The case −2^31 / −1 returns quotient 0x80000000 and remainder 0.
- R3: Let L be the leading-zero count of the absolute dividend. In signed mode a negative dividend is negated first; in unsigned mode the raw value is used. `done` rises exactly 34 − L clock edges after the edge that accepts `start`.
- R4: A dividend whose absolute value has bit 31 set takes the worst case of 34 edges. Examples are 0xFFFFFFFF unsigned and −2^31 signed.
- R5: A zero dividend with a nonzero divisor completes in exactly 2 edges and returns quotient 0 and remainder 0.
- R6: Division by zero takes the normal count from R3. It returns quotient 0xFFFFFFFF and a remainder equal to the dividend. This rule takes precedence over R5.
- R7: `busy` is high in every cycle from the one after the accepting edge up to, but not including, the cycle in which `done` is high. `done` is high for exactly one cycle, and `busy` is low while `done` is high.
- R8: A `start` raised while `busy` is high is ignored. It does not change the running operation's results or latency, and no second operation follows.
- R9: `quotient` and `remainder` change only on the edge that raises `done`. They hold their values at all other times.
- R10: After the synchronous active-high reset, `busy`, `done`, `quotient` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; accepted when `busy` is low |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled on the accepting edge |
| divisor | input | 32 | Divisor, sampled on the accepting edge |
| busy | output | 1 | Operation in progress; the caller should hold |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | 32 | Registered quotient |
| remainder | output | 32 | Registered remainder |

## Verification
Dividends are tried at every magnitude, from zero up to full width. This shows whether the latency follows the leading-zero count rather than a fixed count, and the extremes at 2 and 34 edges pin down both ends of that range. Signed operands are run with all four sign combinations and with the −2^31 / −1 overflow. This separates the sign fixup of the quotient from that of the remainder. Zero divisors, both with a zero dividend and with a nonzero dividend, confirm that the divide-by-zero rule overrides the zero-dividend shortcut. A second `start` injected mid-operation, with different operands, shows whether the running operation is left undisturbed.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } idiv_state_e;

endpackage

// File: rtl/idiv_lzc.sv
module idiv_lzc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] zeros
);
  // Scan upward so that the highest set bit decides the count.
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/idiv_step.sv
module idiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] part_in,
  input  logic         next_bit,
  input  logic [W-1:0] den,
  output logic [W-1:0] part_out,
  output logic         q_bit
);
  logic [W:0] shifted;
  logic [W:0] trial;

  always_comb begin
    shifted  = {part_in, next_bit};
    trial    = shifted - {1'b0, den};
    q_bit    = (shifted >= {1'b0, den});
    part_out = q_bit ? trial[W-1:0] : shifted[W-1:0];
  end
endmodule

// File: rtl/idiv_top.sv
module idiv_top #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  import idiv_pkg::*;

  localparam int CW = $clog2(W) + 1;

  idiv_state_e  st;
  logic [W-1:0] num_raw;
  logic [W-1:0] num_mag;
  logic [W-1:0] den_mag;
  logic         den_zero;
  logic         flip_q;
  logic         flip_r;
  logic [W-1:0] shreg;
  logic [W-1:0] part;
  logic [CW-1:0] steps_left;

  logic [CW-1:0] lead;
  logic [W-1:0]  part_nx;
  logic          qb;

  idiv_lzc #(.W(W)) u_lzc (
    .val   (num_mag),
    .zeros (lead)
  );

  idiv_step #(.W(W)) u_step (
    .part_in  (part),
    .next_bit (shreg[W-1]),
    .den      (den_mag),
    .part_out (part_nx),
    .q_bit    (qb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      quotient   <= '0;
      remainder  <= '0;
      num_raw    <= '0;
      num_mag    <= '0;
      den_mag    <= '0;
      den_zero   <= 1'b0;
      flip_q     <= 1'b0;
      flip_r     <= 1'b0;
      shreg      <= '0;
      part       <= '0;
      steps_left <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            num_raw  <= dividend;
            num_mag  <= (is_signed && dividend[W-1]) ? (~dividend + 1'b1) : dividend;
            den_mag  <= (is_signed && divisor[W-1])  ? (~divisor + 1'b1)  : divisor;
            den_zero <= (divisor == '0);
            flip_q   <= is_signed && (dividend[W-1] ^ divisor[W-1]);
            flip_r   <= is_signed && dividend[W-1];
            busy     <= 1'b1;
            st       <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          // Normalise the dividend so only its significant bits are iterated.
          shreg      <= num_mag << lead;
          part       <= '0;
          steps_left <= CW'(W) - lead;
          st         <= (lead == CW'(W)) ? ST_FIX : ST_ITER;
        end
        ST_ITER: begin
          part       <= part_nx;
          shreg      <= {shreg[W-2:0], qb};
          steps_left <= steps_left - 1'b1;
          if (steps_left == CW'(1)) st <= ST_FIX;
        end
        ST_FIX: begin
          if (den_zero) begin
            quotient  <= '1;
            remainder <= num_raw;
          end else begin
            quotient  <= flip_q ? (~shreg + 1'b1) : shreg;
            remainder <= flip_r ? (~part + 1'b1) : part;
          end
          done <= 1'b1;
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idiv_chk.sv
module idiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         is_signed,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  function automatic int expect_edges(input logic [W-1:0] v, input logic s);
    logic [W-1:0] m;
    int z;
    m = (s && v[W-1]) ? (~v + 1'b1) : v;
    z = W;
    for (int i = 0; i < W; i++) if (m[i]) z = W - 1 - i;
    return W + 2 - z;
  endfunction

  logic [7:0] elapsed;
  logic [7:0] target;
  logic       zero_den;
  logic       live;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed  <= '0;
      target   <= '0;
      zero_den <= 1'b0;
      live     <= 1'b0;
    end else if (start && !busy) begin
      elapsed  <= '0;
      target   <= 8'(expect_edges(dividend, is_signed));
      zero_den <= (divisor == '0);
      live     <= 1'b1;
    end else begin
      if (elapsed != 8'hFF) elapsed <= elapsed + 1'b1;
      if (done) live <= 1'b0;
    end
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    (done && live) |-> (elapsed == target));

  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r9_hold_quotient: assert property (@(posedge clk) disable iff (rst)
    !$stable(quotient) |-> done);

  a_r9_hold_remainder: assert property (@(posedge clk) disable iff (rst)
    !$stable(remainder) |-> done);

  a_r6_zero_divisor: assert property (@(posedge clk) disable iff (rst)
    (done && live && zero_den) |-> (quotient == '1));
endmodule

bind idiv_top idiv_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .is_signed (is_signed),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/tb_idiv_top.sv
`timescale 1ns/1ps
module tb_idiv_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  idiv_top #(.W(W)) dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Runs one division; poke > 0 injects a competing start at that cycle.
  task automatic run_op(input string req, input bit s, input logic [W-1:0] a,
                        input logic [W-1:0] b, input int poke);
    logic [W-1:0] eq, er, mag, q0, r0;
    int lz, n, nexp;
    bit hold_ok, busy_ok;
    if (b == '0) begin
      eq = '1; er = a;
    end else if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      eq = 32'h8000_0000; er = '0;
    end else if (s) begin
      eq = $signed(a) / $signed(b); er = $signed(a) % $signed(b);
    end else begin
      eq = a / b; er = a % b;
    end
    mag = (s && a[W-1]) ? (~a + 1'b1) : a;
    lz = W;
    for (int i = 0; i < W; i++) if (mag[i]) lz = W - 1 - i;
    nexp = W + 2 - lz;

    @(negedge clk);
    is_signed = s; dividend = a; divisor = b; start = 1'b1;
    q0 = quotient; r0 = remainder;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; dividend = ~a; divisor = b ^ 32'h5;
    n = 0; hold_ok = 1'b1; busy_ok = (busy === 1'b1);
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      start = 1'b0;
      if (done === 1'b1 || n > W + 8) break;
      if (busy !== 1'b1) busy_ok = 1'b0;
      if (quotient !== q0 || remainder !== r0) hold_ok = 1'b0;
      if (poke != 0 && n == poke) begin
        start = 1'b1; is_signed = 1'b0; dividend = 32'h1; divisor = 32'h1;
      end
    end
    chk("R3", {req, " latency"}, W'(n), W'(nexp));
    chk(req, "quotient", quotient, eq);
    chk(req, "remainder", remainder, er);
    chk("R7", "busy during op", W'(busy_ok), W'(1));
    chk("R7", "busy at done", W'(busy), W'(0));
    chk("R9", "outputs held before done", W'(hold_ok), W'(1));
    @(negedge clk);
    chk("R7", "done single pulse", W'(done), W'(0));
    chk("R8", "no queued op after done", W'(busy), W'(0));
  endtask

  task automatic t_reset;
    chk("R10", "busy after reset", W'(busy), W'(0));
    chk("R10", "done after reset", W'(done), W'(0));
    chk("R10", "quotient after reset", quotient, '0);
    chk("R10", "remainder after reset", remainder, '0);
  endtask

  task automatic t_unsigned;
    run_op("R1", 1'b0, 32'd100, 32'd7, 0);
    run_op("R1", 1'b0, 32'd5, 32'd9, 0);
    run_op("R1", 1'b0, 32'h0001_2345, 32'd1, 0);
    run_op("R1", 1'b0, 32'hDEAD_BEEF, 32'h0000_1234, 0);
  endtask

  task automatic t_signed;
    run_op("R2", 1'b1, 32'd7, 32'd2, 0);
    run_op("R2", 1'b1, -32'sd7, 32'd2, 0);
    run_op("R2", 1'b1, 32'd7, -32'sd2, 0);
    run_op("R2", 1'b1, -32'sd7, -32'sd2, 0);
    run_op("R2", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_op("R2", 1'b1, 32'h8000_0000, 32'h8000_0000, 0);
  endtask

  task automatic t_worst;
    run_op("R4", 1'b0, 32'hFFFF_FFFF, 32'd3, 0);
    run_op("R4", 1'b1, 32'h8000_0000, 32'd10, 0);
  endtask

  task automatic t_zero_dividend;
    run_op("R5", 1'b0, 32'd0, 32'd13, 0);
    run_op("R5", 1'b1, 32'd0, -32'sd13, 0);
  endtask

  task automatic t_div_zero;
    run_op("R6", 1'b0, 32'h0000_0F00, 32'd0, 0);
    run_op("R6", 1'b1, -32'sd77, 32'd0, 0);
    run_op("R6", 1'b0, 32'd0, 32'd0, 0);
  endtask

  task automatic t_ignore_start;
    run_op("R8", 1'b0, 32'h00FF_0000, 32'd3, 4);
    run_op("R8", 1'b1, -32'sd1000, 32'd7, 1);
  endtask

  task automatic t_random;
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      bit s;
      s = i[0];
      a = $urandom() >> $urandom_range(31, 0);
      b = ($urandom() >> $urandom_range(31, 0)) | 32'd1;
      if (s && $urandom_range(1, 0) == 1) a = ~a + 1'b1;
      if (s && $urandom_range(1, 0) == 1) b = ~b + 1'b1;
      run_op(s ? "R2" : "R1", s, a, b, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_worst();
    t_zero_dividend();
    t_div_zero();
    t_ignore_start();
    t_random();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule